// File: doc/BRIEF.md
# Multi-Plane Write Enable Unit

This block decides which display planes take a CPU memory write. Software first writes a register number to an index port. It then writes a value to a companion data port. When the index selects the plane-select register, the low four bits of that value become the plane mask.

When a CPU memory write lands inside the display window, the block raises one write strobe for each plane whose mask bit is set. A single CPU cycle can therefore store one byte into any mix of planes at once. With all four planes enabled, one write produces a full-intensity white pixel.

The strobes leave the block registered, one clock after the request. The address and data are registered on the same edge, so the plane memories see a matched set. The block holds no memories and does not modify the data.

Top module: `plane_write_gate`

## Requirements
- R1: After reset the index register is 0, the plane mask is 4'b1111 and `plane_we` is 4'b0000.
- R2: An I/O write to port 0x3C4 loads all 8 bits of `io_wdata` into the index register.
- R3: An I/O write to port 0x3C5 while the index equals 0x02 loads `io_wdata[3:0]` into the plane mask. Bits 7..4 are discarded.
- R4: An I/O write to port 0x3C5 while the index is any value other than 0x02 leaves the plane mask unchanged.
- R5: A cycle with `mem_wr` and `win_hit` both high makes `plane_we` equal the plane mask in the following cycle, for exactly that one cycle. Back-to-back writes give one strobe cycle each.
- R6: `plane_we` is 4'b0000 in any cycle that follows a cycle without both `mem_wr` and `win_hit` high.
- R7: In every cycle where `plane_we` is nonzero, `plane_addr` and `plane_wdata` equal the `mem_addr` and `mem_wdata` of the write that raised it.
- R8: I/O writes to any port other than 0x3C4 and 0x3C5 change neither the index nor the mask.
- R9: Mask bit i drives `plane_we[i]` (bit 0 is plane 0). Any combination may be set, and all enabled planes strobe in the same cycle.
- R10: When a mask load and a memory write occur in the same cycle, the memory write uses the mask value from before that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| mem_wr | input | 1 | CPU memory write strobe |
| win_hit | input | 1 | Memory address falls inside the display window |
| mem_addr | input | 16 | Offset within the plane |
| mem_wdata | input | 8 | Byte being written |
| plane_we | output | 4 | Per-plane write enables |
| plane_addr | output | 16 | Address shared by all planes |
| plane_wdata | output | 8 | Data shared by all planes |

## Verification
The assertions check these rules on every cycle:
- a strobe follows a windowed write one clock later with the prior mask (R5);
- no strobe follows any other cycle (R6);
- the strobe never exceeds the mask;
- address and data are aligned with the strobe (R7);
- the mask and index hold across ignored I/O writes (R4, R8).

The bench scenarios cover what needs a longer history:
- the reset values taking effect (R1);
- which bits are discarded when the mask loads (R3);
- the exact mapping of each mask bit to its plane (R9);
- the ordering when a mask load and a memory write share a cycle (R10).

// File: rtl/plane_write_gate.sv
module plane_write_gate #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int          IOW      = 16,
  parameter int          NPLANE   = 4,
  parameter logic [15:0] IDX_PORT = 16'h03C4,
  parameter logic [15:0] DAT_PORT = 16'h03C5,
  parameter logic [7:0]  MASK_SEL = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [IOW-1:0]    io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              mem_wr,
  input  logic              win_hit,
  input  logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_wdata,
  output logic [NPLANE-1:0] plane_we,
  output logic [AW-1:0]     plane_addr,
  output logic [DW-1:0]     plane_wdata
);

  localparam logic [NPLANE-1:0] MASK_RST = {NPLANE{1'b1}};

  logic [7:0]        idx_q;
  logic [NPLANE-1:0] mask_q;

  wire idx_wr  = io_wr && (io_addr == IOW'(IDX_PORT));
  wire mask_wr = io_wr && (io_addr == IOW'(DAT_PORT)) && (idx_q == MASK_SEL);
  wire take    = mem_wr && win_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mask_q <= MASK_RST;
    end else begin
      if (idx_wr)  idx_q  <= io_wdata;
      if (mask_wr) mask_q <= io_wdata[NPLANE-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plane_we    <= '0;
      plane_addr  <= '0;
      plane_wdata <= '0;
    end else begin
      plane_we <= take ? mask_q : '0;
      if (take) begin
        plane_addr  <= mem_addr;
        plane_wdata <= mem_wdata;
      end
    end
  end

  a_r5_strobe_uses_mask: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> plane_we == $past(mask_q));

  a_r6_no_strobe_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> plane_we == '0);

  a_r9_strobe_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (plane_we & ~$past(mask_q)) == '0);

  a_r7_bus_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (plane_addr == $past(mem_addr)) && (plane_wdata == $past(mem_wdata)));

  a_r4_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IOW'(DAT_PORT) && idx_q != MASK_SEL) |=> $stable(mask_q));

  a_r8_foreign_port: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != IOW'(DAT_PORT) && io_addr != IOW'(IDX_PORT))
      |=> ($stable(mask_q) && $stable(idx_q)));

endmodule

// File: tb/plane_write_gate_tb.sv
module plane_write_gate_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        mem_wr = 0;
  logic        win_hit = 0;
  logic [15:0] mem_addr = '0;
  logic [7:0]  mem_wdata = '0;
  logic [3:0]  plane_we;
  logic [15:0] plane_addr;
  logic [7:0]  plane_wdata;

  always #10 clk = ~clk;

  plane_write_gate u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .mem_wr(mem_wr), .win_hit(win_hit), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .plane_we(plane_we), .plane_addr(plane_addr), .plane_wdata(plane_wdata)
  );

  typedef struct {
    logic [3:0]  we;
    logic [15:0] addr;
    logic [7:0]  data;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  logic [7:0] m_idx  = 8'h00;
  logic [3:0] m_mask = 4'hF;
  bit   done = 0;

  task automatic step(input bit iw, input logic [15:0] ia, input logic [7:0] id,
                      input bit mw, input bit hit, input logic [15:0] ma,
                      input logic [7:0] md, input string tag);
    exp_t e;
    @(negedge clk);
    io_wr = iw; io_addr = ia; io_wdata = id;
    mem_wr = mw; win_hit = hit; mem_addr = ma; mem_wdata = md;
    e.we   = (mw && hit) ? m_mask : 4'h0;
    e.addr = ma;
    e.data = md;
    e.tag  = tag;
    exp_q.push_back(e);
    if (iw && ia == 16'h03C4) m_idx = id;
    if (iw && ia == 16'h03C5 && m_idx == 8'h02) m_mask = id[3:0];
  endtask

  task automatic io(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(1, a, d, 0, 0, 16'h0, 8'h0, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(0, 16'h0, 8'h0, 1, 1, a, d, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (plane_we !== e.we) begin
          fails++;
          $display("FAIL %s: plane_we=%h expected %h", e.tag, plane_we, e.we);
        end else if (e.we != 0 && (plane_addr !== e.addr || plane_wdata !== e.data)) begin
          fails++;
          $display("FAIL %s: addr/data=%h/%h expected %h/%h",
                   e.tag, plane_addr, plane_wdata, e.addr, e.data);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (plane_we !== 4'h0) begin
      fails++; $display("FAIL R1: plane_we=%h expected 0", plane_we);
    end
    @(negedge clk); rst_n = 1;
    wr(16'h0010, 8'hFF, "R1 reset mask all planes");
    io(16'h03C4, 8'h02, "R2 index load");
    io(16'h03C5, 8'hA5, "R3 mask load upper bits dropped");
    wr(16'h0020, 8'h3C, "R3 mask 0101");
    io(16'h03C4, 8'h07, "R2 other index");
    io(16'h03C5, 8'h0F, "R4 ignored data write");
    wr(16'h0021, 8'h11, "R4 mask unchanged");
    io(16'h03C4, 8'h82, "R2 index high bit");
    io(16'h03C5, 8'h00, "R4 ignored index 0x82");
    wr(16'h0022, 8'h22, "R4 mask still 0101");
    io(16'h03C4, 8'h02, "R2 back to mask");
    io(16'h03C6, 8'h00, "R8 foreign port");
    io(16'h03D5, 8'h00, "R8 foreign port 2");
    wr(16'h0023, 8'h33, "R8 mask kept");
    io(16'h03C5, 8'h0F, "R9 mask all");
    step(0, 16'h0, 8'h0, 1, 0, 16'h0099, 8'h99, "R6 miss window");
    step(0, 16'h0, 8'h0, 0, 1, 16'h0098, 8'h98, "R6 hit without write");
    wr(16'h1000, 8'hAA, "R5 back to back 1");
    wr(16'h1001, 8'hBB, "R5 back to back 2");
    wr(16'h1002, 8'hCC, "R7 back to back 3");
    for (int i = 0; i < 4; i++) begin
      io(16'h03C5, 8'h01 << i, "R9 single plane select");
      wr(16'h2000 + 16'(i), 8'h40 + 8'(i), "R9 single plane strobe");
    end
    io(16'h03C5, 8'h06, "R9 mask 0110");
    step(1, 16'h03C5, 8'h09, 1, 1, 16'h3000, 8'h5A, "R10 same-cycle uses old mask");
    wr(16'h3001, 8'hA5, "R10 new mask after");
    io(16'h03C5, 8'h00, "R9 mask none");
    wr(16'h3002, 8'h77, "R9 no planes");
    step(0, 16'h0, 8'h0, 0, 0, 16'h0, 8'h0, "R6 idle");
    step(0, 16'h0, 8'h0, 0, 0, 16'h0, 8'h0, "R6 idle");
    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule